// File: doc/BRIEF.md
# Masked register save sequencer

This block spills and reloads a subset of a small register file around a call. On a save request it receives two bit masks, one bit per register. The caller's mask marks the registers that must survive the call. The callee's mask marks the registers the callee will overwrite. Only registers that are marked in both masks are spilled. They are read one at a time from the register file and pushed onto a downward-growing stack. After the last register, the spill mask itself is pushed so that the return path knows which registers to reload. For nested calls, the block also publishes the union of the two masks, which the callee passes to its own callees.

A restore request reverses the process. It pops the stored mask, then reloads each marked register from the stack into the register file, highest register first. While either operation runs, the block holds a dispatch stall. The registers involved are not known until the mask has been resolved, so later instructions must not issue during that time.

The stack port is a valid/ready request channel. While `stk_valid` is high and `stk_ready` is low, the block keeps its address, direction and write data unchanged and makes no progress. A request completes in the cycle where both signals are high. For reads, `stk_rdata` must carry the addressed word in that same cycle. The register-file ports are plain: the read data must be valid in the cycle `rf_rd_en` is high, and a write takes effect in the cycle `rf_wr_en` is high.

Top module: `reg_spill_seq`

## Requirements
- R1: A save reads and pushes exactly the registers whose bits are set in (live_mask AND used_mask), where bit i of each mask stands for register i.
- R2: From the cycle after an accepted save, fwd_mask equals live_mask OR used_mask as sampled at the start, and it keeps that value until the next accepted save.
- R3: Spilled registers go out in ascending register-number order. Each one is written at the current stack pointer, and the stack pointer then decreases by one.
- R4: After the last register, the spill mask is written, zero-extended, at the next lower address. After a save of n registers, stk_ptr is therefore n+1 below its starting value.
- R5: A restore first pops the stored mask from stk_ptr+1. It then reloads the marked registers in descending register-number order, incrementing the pointer before each read, and finishes with stk_ptr back at its value before the matching save.
- R6: When the AND mask is all zeros, a save reads no registers and makes exactly one stack write (the mask). done then rises in the second cycle after start.
- R7: stall is high from the cycle after an accepted start through the cycle in which done is high, and low in all other cycles. With stk_ready held high, a save of n registers stalls for n+2 cycles.
- R8: done is high for exactly one cycle per operation.
- R9: save_start and restore_start are ignored while stall is high. The outputs and stack contents are the same as if they had never been pulsed.
- R10: While stk_valid is high and stk_ready is low, stk_addr and stk_write stay stable, no stack or register write happens, and the operation does not advance.
- R11: If save_start and restore_start are high together while idle, the save is performed and the restore is dropped.
- R12: After reset, stall, done and stk_valid are low, fwd_mask is zero and stk_ptr equals SP_INIT (63 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_start | input | 1 | Begin a save (pulse) |
| restore_start | input | 1 | Begin a restore (pulse) |
| live_mask | input | NREG | Caller's live-register mask |
| used_mask | input | NREG | Callee's used-register mask |
| stall | output | 1 | Dispatch stall |
| done | output | 1 | One-cycle completion pulse |
| fwd_mask | output | NREG | Mask for deeper calls (live OR used) |
| stk_ptr | output | AW | Current stack pointer |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rd_idx | output | log2(NREG) | Register to read |
| rf_rd_data | input | DW | Read data, valid in the same cycle |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wr_idx | output | log2(NREG) | Register to write |
| rf_wr_data | output | DW | Register write data |
| stk_valid | output | 1 | Stack request valid |
| stk_write | output | 1 | 1 = push (write), 0 = pop (read) |
| stk_addr | output | AW | Stack word address |
| stk_wdata | output | DW | Stack write data |
| stk_ready | input | 1 | Stack accepts the request this cycle |
| stk_rdata | input | DW | Stack read data, valid with stk_ready |

## Verification
The bench targets the empty intersection first. A design that skips the mask push, or that reads a register anyway, leaves the pointer off by one and breaks the matching restore. Both edges of the mask are covered (register 0, register 15, all sixteen set), where a priority picker with an off-by-one index would spill the wrong register or hang. Pulses of either start during a busy operation, simultaneous starts, and a stalled stack port all check that no state moves when it must not. A design that advanced or restarted in those cases would corrupt the stack contents, fwd_mask or the stall length. Round-trip restores check descending order and pointer balance, which a wrong pre- or post-increment would break.

// File: rtl/spill_pkg.sv
package spill_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SAVE_REG,
    SQ_SAVE_MASK,
    SQ_LOAD_MASK,
    SQ_LOAD_REG,
    SQ_FIN
  } sq_state_e;
endpackage

// File: rtl/spill_mask_calc.sv
module spill_mask_calc #(
  parameter int N = 16
) (
  input  logic [N-1:0] live,
  input  logic [N-1:0] used,
  output logic [N-1:0] save_m,
  output logic [N-1:0] fwd_m,
  output logic         save_none
);
  always_comb begin
    save_m    = live & used;
    fwd_m     = live | used;
    save_none = ~|save_m;
  end
endmodule

// File: rtl/spill_bit_pick.sv
module spill_bit_pick #(
  parameter int N         = 16,
  parameter bit LOW_FIRST = 1'b1
) (
  input  logic [N-1:0]         vec,
  output logic [$clog2(N)-1:0] idx
);
  localparam int IW = $clog2(N);

  generate
    if (LOW_FIRST) begin : g_low
      always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--)
          if (vec[i]) idx = IW'(i);
      end
    end else begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
          if (vec[i]) idx = IW'(i);
      end
    end
  endgenerate

  // R3
  always_comb begin
    if (|vec) begin
      pick_hit_chk: assert (vec[idx]);
    end
  end
endmodule

// File: rtl/reg_spill_seq.sv
module reg_spill_seq #(
  parameter int NREG    = 16,
  parameter int DW      = 32,
  parameter int AW      = 6,
  parameter int SP_INIT = (1 << AW) - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    save_start,
  input  logic                    restore_start,
  input  logic [NREG-1:0]         live_mask,
  input  logic [NREG-1:0]         used_mask,
  output logic                    stall,
  output logic                    done,
  output logic [NREG-1:0]         fwd_mask,
  output logic [AW-1:0]           stk_ptr,
  output logic                    rf_rd_en,
  output logic [$clog2(NREG)-1:0] rf_rd_idx,
  input  logic [DW-1:0]           rf_rd_data,
  output logic                    rf_wr_en,
  output logic [$clog2(NREG)-1:0] rf_wr_idx,
  output logic [DW-1:0]           rf_wr_data,
  output logic                    stk_valid,
  output logic                    stk_write,
  output logic [AW-1:0]           stk_addr,
  output logic [DW-1:0]           stk_wdata,
  input  logic                    stk_ready,
  input  logic [DW-1:0]           stk_rdata
);
  import spill_pkg::*;

  localparam int IW = $clog2(NREG);

  sq_state_e       state;
  logic [NREG-1:0] pend, kept_mask;
  logic [NREG-1:0] save_m, fwd_m;
  logic            save_none;
  logic [IW-1:0]   lo_idx, hi_idx;
  logic [NREG-1:0] pend_clr_lo, pend_clr_hi;
  logic [NREG-1:0] pop_mask;

  spill_mask_calc #(.N(NREG)) u_mask (
    .live(live_mask), .used(used_mask),
    .save_m(save_m), .fwd_m(fwd_m), .save_none(save_none)
  );

  spill_bit_pick #(.N(NREG), .LOW_FIRST(1'b1)) u_pick_lo (
    .vec(pend), .idx(lo_idx)
  );

  spill_bit_pick #(.N(NREG), .LOW_FIRST(1'b0)) u_pick_hi (
    .vec(pend), .idx(hi_idx)
  );

  assign pend_clr_lo = pend & ~(NREG'(1) << lo_idx);
  assign pend_clr_hi = pend & ~(NREG'(1) << hi_idx);
  assign pop_mask    = stk_rdata[NREG-1:0];

  always_comb begin
    stall      = (state != SQ_IDLE);
    done       = (state == SQ_FIN);
    stk_write  = (state == SQ_SAVE_REG) || (state == SQ_SAVE_MASK);
    stk_valid  = stk_write || (state == SQ_LOAD_MASK) || (state == SQ_LOAD_REG);
    stk_addr   = stk_write ? stk_ptr : stk_ptr + AW'(1);
    stk_wdata  = (state == SQ_SAVE_REG) ? rf_rd_data : DW'(kept_mask);
    rf_rd_en   = (state == SQ_SAVE_REG);
    rf_rd_idx  = lo_idx;
    rf_wr_en   = (state == SQ_LOAD_REG) && stk_ready;
    rf_wr_idx  = hi_idx;
    rf_wr_data = stk_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      pend      <= '0;
      kept_mask <= '0;
      fwd_mask  <= '0;
      stk_ptr   <= AW'(SP_INIT);
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (save_start) begin
            kept_mask <= save_m;
            pend      <= save_m;
            fwd_mask  <= fwd_m;
            state     <= save_none ? SQ_SAVE_MASK : SQ_SAVE_REG;
          end else if (restore_start) begin
            state <= SQ_LOAD_MASK;
          end
        end
        SQ_SAVE_REG: if (stk_ready) begin
          stk_ptr <= stk_ptr - AW'(1);
          pend    <= pend_clr_lo;
          if (pend_clr_lo == '0) state <= SQ_SAVE_MASK;
        end
        SQ_SAVE_MASK: if (stk_ready) begin
          stk_ptr <= stk_ptr - AW'(1);
          state   <= SQ_FIN;
        end
        SQ_LOAD_MASK: if (stk_ready) begin
          stk_ptr <= stk_ptr + AW'(1);
          pend    <= pop_mask;
          state   <= (pop_mask == '0) ? SQ_FIN : SQ_LOAD_REG;
        end
        SQ_LOAD_REG: if (stk_ready) begin
          stk_ptr <= stk_ptr + AW'(1);
          pend    <= pend_clr_hi;
          if (pend_clr_hi == '0) state <= SQ_FIN;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R7
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && (save_start || restore_start)) |=> stall);

  // R7
  done_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stall);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr) && $stable(stk_write)));

  // R3
  sp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && stk_ready && stk_write) |=> (stk_ptr == $past(stk_ptr) - AW'(1)));

  // R5
  sp_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && stk_ready && !stk_write) |=> (stk_ptr == $past(stk_ptr) + AW'(1)));

  // R9
  fwd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fwd_mask));
endmodule

// File: tb/tb_reg_spill_seq.sv
module tb_reg_spill_seq;
  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int AW   = 6;
  localparam int IW   = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            save_start = 1'b0, restore_start = 1'b0;
  logic [NREG-1:0] live_mask = '0, used_mask = '0;
  logic            stall, done, rf_rd_en, rf_wr_en, stk_valid, stk_write;
  logic [NREG-1:0] fwd_mask;
  logic [AW-1:0]   stk_ptr, stk_addr;
  logic [IW-1:0]   rf_rd_idx, rf_wr_idx;
  logic [DW-1:0]   rf_rd_data, rf_wr_data, stk_wdata, stk_rdata;
  logic            stk_ready = 1'b1;

  logic [DW-1:0] rf  [0:NREG-1];
  logic [DW-1:0] mem [0:(1<<AW)-1];
  assign rf_rd_data = rf[rf_rd_idx];
  assign stk_rdata  = mem[stk_addr];

  reg_spill_seq #(.NREG(NREG), .DW(DW), .AW(AW)) dut (.*);

  // monitor: sole writer of the stack model and the logs
  logic            log_clear = 1'b0;
  int              rd_cnt, wr_cnt, order_err, last_idx;
  logic [NREG-1:0] rest_mask;
  logic [DW-1:0]   rest_val [0:NREG-1];
  always @(posedge clk) begin
    if (log_clear) begin
      rd_cnt <= 0; wr_cnt <= 0; order_err <= 0; last_idx <= NREG;
      rest_mask <= '0;
    end else begin
      if (rf_rd_en && stk_ready) rd_cnt <= rd_cnt + 1;
      if (stk_valid && stk_write && stk_ready) begin
        mem[stk_addr] <= stk_wdata;
        wr_cnt <= wr_cnt + 1;
      end
      if (rf_wr_en) begin
        rest_val[rf_wr_idx] <= rf_wr_data;
        rest_mask[rf_wr_idx] <= 1'b1;
        if (int'(rf_wr_idx) >= last_idx) order_err <= order_err + 1;
        last_idx <= int'(rf_wr_idx);
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rv(input int v, input int i);
    return 32'hC0DE_0000 | (v << 8) | i;
  endfunction

  task automatic clear_log();
    log_clear = 1'b1;
    @(negedge clk);
    log_clear = 1'b0;
  endtask

  int cyc;
  task automatic pulse(input bit s, input bit r, input logic [15:0] lv, input logic [15:0] us);
    live_mask = lv; used_mask = us; save_start = s; restore_start = r;
    @(negedge clk);
    save_start = 1'b0; restore_start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    cyc = 0;
    forever begin
      if (stall) cyc++;
      if (done) break;
      guard++;
      if (guard > 400) begin
        chk(1'b0, "watchdog", "op timeout", 32'(guard), 32'd400);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    chk(!done && !stall, "R8", "done single cycle", {30'd0, done, stall}, 32'd0);
  endtask

  localparam logic [31:0] VEC [0:5] = '{
    32'hFFFF_0001, 32'h00F0_0F30, 32'h8001_8001,
    32'hAAAA_5555, 32'hFFFF_FFFF, 32'h1234_0FF0 };

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "global timeout", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [AW-1:0]   sp0;
    logic [15:0]     lv, us, sm;
    int              n, k;
    bit              ok;
    for (int i = 0; i < NREG; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_log();

    // R12 reset state
    chk(!stall && !done && !stk_valid, "R12", "idle outputs", {29'd0, stall, done, stk_valid}, 32'd0);
    chk(fwd_mask == '0, "R12", "fwd_mask", 32'(fwd_mask), 32'd0);
    chk(stk_ptr == 6'd63, "R12", "stk_ptr", 32'(stk_ptr), 32'd63);

    // table of vectors: save then restore round trip
    for (int v = 0; v < 6; v++) begin
      lv = VEC[v][31:16]; us = VEC[v][15:0]; sm = lv & us; n = $countones(sm);
      for (int i = 0; i < NREG; i++) rf[i] = rv(v, i);
      sp0 = stk_ptr;
      clear_log();
      pulse(1'b1, 1'b0, lv, us);
      wait_done();
      chk(fwd_mask == (lv | us), "R2", "fwd_mask", 32'(fwd_mask), 32'(lv | us));
      chk(cyc == n + 2, "R7", "stall cycles", 32'(cyc), 32'(n + 2));
      chk(rd_cnt == n, "R1", "register reads", 32'(rd_cnt), 32'(n));
      if (n == 0) chk(wr_cnt == 1, "R6", "only mask pushed", 32'(wr_cnt), 32'd1);
      ok = 1'b1; k = 0;
      for (int i = 0; i < NREG; i++)
        if (sm[i]) begin
          if (mem[sp0 - AW'(k)] != rv(v, i)) ok = 1'b0;
          k++;
        end
      chk(ok, "R3", "ascending spill contents", 32'(v), 32'(v));
      chk(mem[sp0 - AW'(n)] == 32'(sm), "R4", "mask pushed last", mem[sp0 - AW'(n)], 32'(sm));
      chk(stk_ptr == sp0 - AW'(n + 1), "R4", "sp after save", 32'(stk_ptr), 32'(sp0 - AW'(n + 1)));

      clear_log();
      pulse(1'b0, 1'b1, '0, '0);
      wait_done();
      chk(stk_ptr == sp0, "R5", "sp after restore", 32'(stk_ptr), 32'(sp0));
      chk(rest_mask == sm, "R5", "restored set", 32'(rest_mask), 32'(sm));
      ok = 1'b1;
      for (int i = 0; i < NREG; i++)
        if (sm[i] && rest_val[i] != rv(v, i)) ok = 1'b0;
      chk(ok, "R5", "restored values", 32'(v), 32'(v));
      chk(order_err == 0, "R5", "descending order", 32'(order_err), 32'd0);
    end

    // R9 starts during a busy save are ignored
    for (int i = 0; i < NREG; i++) rf[i] = rv(9, i);
    sp0 = stk_ptr;
    clear_log();
    pulse(1'b1, 1'b0, 16'h0F0F, 16'h00FF);
    pulse(1'b1, 1'b1, 16'h8000, 16'h8000);
    pulse(1'b0, 1'b1, 16'h8000, 16'h8000);
    wait_done();
    chk(fwd_mask == 16'h0FFF, "R9", "fwd_mask unchanged", 32'(fwd_mask), 32'h0FFF);
    chk(wr_cnt == 5, "R9", "stack writes", 32'(wr_cnt), 32'd5);
    chk(stk_ptr == sp0 - AW'(5), "R9", "sp", 32'(stk_ptr), 32'(sp0 - AW'(5)));
    chk(mem[sp0 - AW'(4)] == 32'h000F, "R9", "mask stored", mem[sp0 - AW'(4)], 32'h000F);
    @(negedge clk);
    chk(!stall, "R9", "no extra operation", 32'(stall), 32'd0);
    pulse(1'b0, 1'b1, '0, '0);
    wait_done();
    chk(stk_ptr == sp0, "R9", "balanced restore", 32'(stk_ptr), 32'(sp0));

    // R10 back-pressure on the stack port
    sp0 = stk_ptr;
    clear_log();
    stk_ready = 1'b0;
    pulse(1'b1, 1'b0, 16'h0003, 16'h0003);
    ok = 1'b1;
    for (int t = 0; t < 3; t++) begin
      if (!stk_valid || !stk_write || stk_addr != sp0 || stk_ptr != sp0) ok = 1'b0;
      @(negedge clk);
    end
    chk(ok, "R10", "request held", 32'(stk_addr), 32'(sp0));
    chk(wr_cnt == 0 && rd_cnt == 0, "R10", "no progress", 32'(wr_cnt), 32'd0);
    stk_ready = 1'b1;
    wait_done();
    chk(mem[sp0] == rv(9, 0) && mem[sp0 - AW'(1)] == rv(9, 1), "R10", "data after release",
        mem[sp0], rv(9, 0));
    chk(mem[sp0 - AW'(2)] == 32'h0003, "R4", "mask after stall", mem[sp0 - AW'(2)], 32'h0003);
    pulse(1'b0, 1'b1, '0, '0);
    wait_done();

    // R11 simultaneous starts: save wins
    sp0 = stk_ptr;
    clear_log();
    pulse(1'b1, 1'b1, 16'h4000, 16'h4100);
    chk(stk_valid && stk_write, "R11", "save chosen", {30'd0, stk_valid, stk_write}, 32'd3);
    wait_done();
    chk(fwd_mask == 16'h4100, "R11", "fwd_mask", 32'(fwd_mask), 32'h4100);
    chk(stk_ptr == sp0 - AW'(2), "R11", "sp", 32'(stk_ptr), 32'(sp0 - AW'(2)));
    chk(rd_cnt == 1, "R1", "single read", 32'(rd_cnt), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule